// File: doc/BRIEF.md
# Character Display Command Core

This block is the command side of a dot-matrix character display controller. A host talks to it over a synchronous register bus. One select line chooses between the command path and the data path, and one line chooses read or write. Command writes are decoded by the position of their highest set bit. They update an address counter, the entry rules, the on/off flags for the screen, the cursor and the blink, and a horizontal shift offset for the visible window.

Data writes and reads go to a 128-byte display memory or a 64-byte glyph memory. Which one is used depends on the kind of address that was loaded last. After each access the address counter steps according to the entry rules and the line layout. Every accepted operation holds a busy flag for a parameterised number of cycles, and the host polls that flag through a status read. A blink phase output toggles at a fixed period while blink is enabled.

Top module: `lcd_cmd_core`

## Requirements
- R1: A command byte is decoded by its highest set bit: bit 7 loads a 7-bit display address, bit 6 loads a 6-bit glyph address (bits 5:0), bit 5 sets the line mode (bit 3 = 1 two lines), bit 4 is a cursor/window shift (bit 3 = 1 window, bit 2 = 1 right), bit 3 sets flags (bit 2 screen, bit 1 cursor, bit 0 blink), bit 2 sets entry rules (bit 1 = 1 increment, bit 0 = 1 shift window on write), bit 1 is home, bit 0 is clear. The byte 0x00 is a no-op that does not raise busy.
- R2: Every accepted data write, and every data read that is not a dummy read, steps the address counter by one: up when the increment bit is set and down when it is clear.
- R3: With the window-shift bit set, each display-memory write moves the shift offset. When incrementing it moves left (offset +1), and when decrementing it moves right (offset −1). Data reads never change the offset.
- R4: A cursor shift (command bit 3 = 0) steps the address counter down on left and up on right, and marks the next read valid. A window shift changes only the offset, with +1 for left and −1 for right, and wraps at the line length.
- R5: In two-line mode the display address runs 0x00–0x27 then 0x40–0x67 and wraps in both directions, so 0x27+1 = 0x40 and 0x00−1 = 0x67; the offset wraps modulo 40. In one-line mode the address and the offset wrap modulo 80. Glyph addresses wrap within 6 bits.
- R6: Home sets the address counter and the offset to 0 and leaves the display memory as it is. Clear does the same, fills the whole display memory with 0x20 and forces the increment bit to 1.
- R7: The first data read after an address load, a clear, a home or a data write returns 0xFF and leaves the address counter unchanged. The reads after it return memory contents.
- R8: An accepted clear or home holds busy high for exactly T_LONG cycles. Any other accepted command, data read or data write holds it for exactly T_SHORT cycles.
- R9: While busy, every access except a status read is ignored and pulses ins_drop high for one cycle.
- R10: A status read (select 0, read) returns {busy, address counter} on bus_rdata in the next cycle, whether or not the core is busy.
- R11: While blink is on, blink_phase toggles every BLINK_CYC cycles. When blink is off, blink_phase is 0.
- R12: After reset the address, the offset, all flags, busy, ins_drop and bus_rdata are 0, and the mode is one line with increment and no window shift.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | One-cycle access strobe |
| bus_rs | input | 1 | 0 = command/status, 1 = data |
| bus_rw | input | 1 | 1 = read, 0 = write |
| bus_wdata | input | 8 | Write byte |
| bus_rdata | output | 8 | Read byte, valid the cycle after a read |
| busy | output | 1 | Execution in progress |
| ins_drop | output | 1 | Pulse: access rejected while busy |
| cursor_addr | output | 7 | Address counter |
| shift_ofs | output | 7 | Window shift offset |
| disp_on | output | 1 | Screen enable |
| cursor_on | output | 1 | Cursor enable |
| blink_on | output | 1 | Blink enable |
| blink_phase | output | 1 | Current blink phase |

## Verification
The bench builds the core with T_SHORT = 4, T_LONG = 12 and BLINK_CYC = 8. These values keep both busy windows short enough to count cycle by cycle, and they leave enough busy cycles after a command to place a status read and a rejected write inside the window. A blink period of eight cycles makes a full toggle interval measurable within a few dozen cycles. Line wraps, the dummy read and glyph-address rollover are not affected by these parameters, so the bench reaches them at the true address boundaries.

// File: rtl/lcd_cmd_pkg.sv
package lcd_cmd_pkg;

  localparam int DD_AW = 7;
  localparam int CG_AW = 6;
  localparam logic [7:0] BLANK_CODE = 8'h20;
  localparam logic [7:0] STALE_BYTE = 8'hFF;

  typedef enum logic [3:0] {
    OP_NOP, OP_CLEAR, OP_HOME, OP_ENTRY, OP_FLAGS,
    OP_SHIFT, OP_MODE, OP_CGADDR, OP_DDADDR
  } op_e;

  // highest set bit selects the command
  function automatic op_e op_decode(input logic [7:0] b);
    if (b[7])      return OP_DDADDR;
    else if (b[6]) return OP_CGADDR;
    else if (b[5]) return OP_MODE;
    else if (b[4]) return OP_SHIFT;
    else if (b[3]) return OP_FLAGS;
    else if (b[2]) return OP_ENTRY;
    else if (b[1]) return OP_HOME;
    else if (b[0]) return OP_CLEAR;
    else           return OP_NOP;
  endfunction

  // address counter step under the line layout
  function automatic logic [6:0] ac_next(input logic [6:0] ac, input logic up,
                                         input logic cg, input logic two);
    logic [5:0] g;
    if (cg) begin
      g = up ? ac[5:0] + 6'd1 : ac[5:0] - 6'd1;
      return {1'b0, g};
    end
    if (two) begin
      if (up) begin
        if (ac == 7'h27) return 7'h40;
        if (ac == 7'h67) return 7'h00;
        return ac + 7'd1;
      end
      if (ac == 7'h40) return 7'h27;
      if (ac == 7'h00) return 7'h67;
      return ac - 7'd1;
    end
    if (up) return (ac == 7'h4F) ? 7'h00 : ac + 7'd1;
    return (ac == 7'h00) ? 7'h4F : ac - 7'd1;
  endfunction

  // window offset step, left moves up
  function automatic logic [6:0] ofs_next(input logic [6:0] ofs, input logic left,
                                          input logic two);
    logic [6:0] last;
    last = two ? 7'd39 : 7'd79;
    if (left) return (ofs >= last) ? 7'd0 : ofs + 7'd1;
    return (ofs == 7'd0) ? last : ofs - 7'd1;
  endfunction

endpackage

// File: rtl/lcd_busy_timer.sv
module lcd_busy_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          busy
);
  logic [CW-1:0] remain;

  always_ff @(posedge clk) begin
    if (!rst_n)             remain <= '0;
    else if (load)          remain <= load_val;
    else if (remain != '0)  remain <= remain - 1'b1;
  end

  assign busy = (remain != '0);
endmodule

// File: rtl/lcd_byte_ram.sv
module lcd_byte_ram #(
  parameter int         AW   = 6,
  parameter logic [7:0] FILL = 8'h00
) (
  input  logic          clk,
  input  logic          we,
  input  logic          clr,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  output logic [7:0]    rdata
);
  localparam int DEPTH = 1 << AW;
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (clr) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= FILL;
    end else if (we) begin
      mem[addr] <= wdata;
    end
  end

  assign rdata = mem[addr];
endmodule

// File: rtl/lcd_cmd_core.sv
module lcd_cmd_core
  import lcd_cmd_pkg::*;
#(
  parameter int T_SHORT   = 100,
  parameter int T_LONG    = 410,
  parameter int BLINK_CYC = 100000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_valid,
  input  logic       bus_rs,
  input  logic       bus_rw,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       busy,
  output logic       ins_drop,
  output logic [6:0] cursor_addr,
  output logic [6:0] shift_ofs,
  output logic       disp_on,
  output logic       cursor_on,
  output logic       blink_on,
  output logic       blink_phase
);
  localparam int TW = $clog2(T_LONG + T_SHORT + 1);
  localparam int BW = $clog2(BLINK_CYC + 1);

  logic inc_mode, win_shift, two_line, sel_cg, stale;
  logic [BW-1:0] blink_cnt;
  logic [7:0] dd_q, cg_q, rd_byte;

  // named events for the checker
  logic ev_status, ev_ir_wr, ev_dr_wr, ev_dr_rd, ev_drop, ev_home, ev_clear, ev_load;
  op_e  op;

  assign op        = op_decode(bus_wdata);
  assign ev_status = bus_valid && !bus_rs && bus_rw;
  assign ev_ir_wr  = bus_valid && !bus_rs && !bus_rw && !busy;
  assign ev_dr_wr  = bus_valid && bus_rs && !bus_rw && !busy;
  assign ev_dr_rd  = bus_valid && bus_rs && bus_rw && !busy;
  assign ev_drop   = bus_valid && busy && !ev_status;
  assign ev_clear  = ev_ir_wr && (op == OP_CLEAR);
  assign ev_home   = ev_ir_wr && (op == OP_HOME);
  assign ev_load   = (ev_ir_wr && op != OP_NOP) || ev_dr_wr || ev_dr_rd;

  lcd_busy_timer #(.CW(TW)) timer_i (
    .clk(clk), .rst_n(rst_n), .load(ev_load),
    .load_val((ev_clear || ev_home) ? TW'(T_LONG) : TW'(T_SHORT)),
    .busy(busy)
  );

  lcd_byte_ram #(.AW(DD_AW), .FILL(BLANK_CODE)) dd_i (
    .clk(clk), .we(ev_dr_wr && !sel_cg), .clr(ev_clear),
    .addr(cursor_addr), .wdata(bus_wdata), .rdata(dd_q)
  );

  lcd_byte_ram #(.AW(CG_AW), .FILL(8'h00)) cg_i (
    .clk(clk), .we(ev_dr_wr && sel_cg), .clr(1'b0),
    .addr(cursor_addr[CG_AW-1:0]), .wdata(bus_wdata), .rdata(cg_q)
  );

  assign rd_byte = sel_cg ? cg_q : dd_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cursor_addr <= '0; shift_ofs <= '0;
      inc_mode <= 1'b1;  win_shift <= 1'b0; two_line <= 1'b0;
      sel_cg <= 1'b0;    stale <= 1'b1;
      disp_on <= 1'b0;   cursor_on <= 1'b0; blink_on <= 1'b0;
      bus_rdata <= '0;   ins_drop <= 1'b0;
    end else begin
      ins_drop <= ev_drop;
      if (ev_status) bus_rdata <= {busy, cursor_addr};
      if (ev_ir_wr) begin
        unique case (op)
          OP_CLEAR: begin
            cursor_addr <= '0; shift_ofs <= '0; inc_mode <= 1'b1;
            sel_cg <= 1'b0; stale <= 1'b1;
          end
          OP_HOME: begin
            cursor_addr <= '0; shift_ofs <= '0; sel_cg <= 1'b0; stale <= 1'b1;
          end
          OP_ENTRY: begin inc_mode <= bus_wdata[1]; win_shift <= bus_wdata[0]; end
          OP_FLAGS: begin
            disp_on <= bus_wdata[2]; cursor_on <= bus_wdata[1]; blink_on <= bus_wdata[0];
          end
          OP_SHIFT: begin
            if (bus_wdata[3]) shift_ofs <= ofs_next(shift_ofs, !bus_wdata[2], two_line);
            else begin
              cursor_addr <= ac_next(cursor_addr, bus_wdata[2], sel_cg, two_line);
              stale <= 1'b0;
            end
          end
          OP_MODE:   two_line <= bus_wdata[3];
          OP_CGADDR: begin cursor_addr <= {1'b0, bus_wdata[5:0]}; sel_cg <= 1'b1; stale <= 1'b1; end
          OP_DDADDR: begin cursor_addr <= bus_wdata[6:0]; sel_cg <= 1'b0; stale <= 1'b1; end
          default: ;
        endcase
      end
      if (ev_dr_wr) begin
        cursor_addr <= ac_next(cursor_addr, inc_mode, sel_cg, two_line);
        if (win_shift && !sel_cg) shift_ofs <= ofs_next(shift_ofs, inc_mode, two_line);
        stale <= 1'b1;
      end
      if (ev_dr_rd) begin
        if (stale) begin
          bus_rdata <= STALE_BYTE;
          stale <= 1'b0;
        end else begin
          bus_rdata <= rd_byte;
          cursor_addr <= ac_next(cursor_addr, inc_mode, sel_cg, two_line);
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !blink_on) begin
      blink_cnt <= '0; blink_phase <= 1'b0;
    end else if (blink_cnt == BW'(BLINK_CYC - 1)) begin
      blink_cnt <= '0; blink_phase <= !blink_phase;
    end else begin
      blink_cnt <= blink_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/lcd_cmd_core_chk.sv
module lcd_cmd_core_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bus_valid,
  input logic       bus_rs,
  input logic       bus_rw,
  input logic [7:0] bus_rdata,
  input logic       busy,
  input logic       ins_drop,
  input logic [6:0] cursor_addr,
  input logic [6:0] shift_ofs,
  input logic       blink_on,
  input logic       blink_phase,
  input logic       ev_home,
  input logic       ev_load
);
  assert_drop_when_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ins_drop |-> $past(busy));

  assert_busy_freezes_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && busy && !(!bus_rs && bus_rw)) |=> ($stable(cursor_addr) && $stable(shift_ofs)));

  assert_home_zeroes_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_home |=> (cursor_addr == 7'd0 && shift_ofs == 7'd0));

  assert_status_word_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_rs && bus_rw) |=> (bus_rdata == {$past(busy), $past(cursor_addr)}));

  assert_load_sets_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_load |=> busy);

  assert_blink_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !blink_on |=> !blink_phase);
endmodule

bind lcd_cmd_core lcd_cmd_core_chk chk_i (
  .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_rs(bus_rs), .bus_rw(bus_rw),
  .bus_rdata(bus_rdata), .busy(busy), .ins_drop(ins_drop), .cursor_addr(cursor_addr),
  .shift_ofs(shift_ofs), .blink_on(blink_on), .blink_phase(blink_phase),
  .ev_home(ev_home), .ev_load(ev_load)
);

// File: tb/lcd_cmd_core_tb_top.sv
module lcd_cmd_core_tb_top;
  localparam int TS = 4, TL = 12, BC = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_valid = 1'b0, bus_rs = 1'b0, bus_rw = 1'b0;
  logic [7:0] bus_wdata = '0, bus_rdata;
  logic busy, ins_drop, disp_on, cursor_on, blink_on, blink_phase;
  logic [6:0] cursor_addr, shift_ofs;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  lcd_cmd_core #(.T_SHORT(TS), .T_LONG(TL), .BLINK_CYC(BC)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_rs(bus_rs), .bus_rw(bus_rw),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .busy(busy), .ins_drop(ins_drop),
    .cursor_addr(cursor_addr), .shift_ofs(shift_ofs), .disp_on(disp_on),
    .cursor_on(cursor_on), .blink_on(blink_on), .blink_phase(blink_phase)
  );

  // {rs, rw, byte, expected address, expected offset}
  localparam logic [23:0] VEC [21] = '{
    {1'b0,1'b0,8'h38,7'h00,7'd0},  {1'b0,1'b0,8'h01,7'h00,7'd0},
    {1'b0,1'b0,8'h06,7'h00,7'd0},  {1'b0,1'b0,8'hA6,7'h26,7'd0},
    {1'b1,1'b0,8'h41,7'h27,7'd0},  {1'b1,1'b0,8'h42,7'h40,7'd0},
    {1'b0,1'b0,8'h10,7'h27,7'd0},  {1'b0,1'b0,8'h14,7'h40,7'd0},
    {1'b0,1'b0,8'h07,7'h40,7'd0},  {1'b1,1'b0,8'h43,7'h41,7'd1},
    {1'b0,1'b0,8'h05,7'h41,7'd1},  {1'b1,1'b0,8'h44,7'h40,7'd0},
    {1'b1,1'b0,8'h45,7'h27,7'd39}, {1'b0,1'b0,8'h18,7'h27,7'd0},
    {1'b0,1'b0,8'h1C,7'h27,7'd39}, {1'b0,1'b0,8'h02,7'h00,7'd0},
    {1'b0,1'b0,8'h80,7'h00,7'd0},  {1'b0,1'b0,8'h04,7'h00,7'd0},
    {1'b1,1'b0,8'h46,7'h67,7'd0},  {1'b0,1'b0,8'h06,7'h67,7'd0},
    {1'b0,1'b0,8'h80,7'h00,7'd0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic rs, input logic rw, input logic [7:0] d);
    bus_rs = rs; bus_rw = rw; bus_wdata = d; bus_valid = 1'b1;
    @(negedge clk);
    bus_valid = 1'b0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  task automatic acc(input logic rs, input logic rw, input logic [7:0] d);
    wait_idle();
    drive(rs, rw, d);
  endtask

  task automatic busy_len(output int n);
    n = 0;
    while (busy) begin n++; @(negedge clk); end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int n;
    logic [6:0] ac_hold;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12 reset state
    check("R12 addr", cursor_addr, 0); check("R12 ofs", shift_ofs, 0);
    check("R12 flags", {disp_on, cursor_on, blink_on, blink_phase, busy, ins_drop}, 0);
    check("R12 rdata", bus_rdata, 0);

    for (int i = 0; i < 21; i++) begin
      acc(VEC[i][23], VEC[i][22], VEC[i][21:14]);
      wait_idle();
      check($sformatf("R1 R2 R3 R4 R5 R6 vec%0d addr", i), cursor_addr, VEC[i][13:7]);
      check($sformatf("R3 R4 R5 vec%0d ofs", i), shift_ofs, VEC[i][6:0]);
    end

    // R7 dummy read, R2 read stepping, R3 reads do not shift
    acc(0, 0, 8'h07); acc(0, 0, 8'hA7);
    acc(1, 1, 8'h00); check("R7 dummy byte", bus_rdata, 8'hFF); check("R7 addr held", cursor_addr, 7'h27);
    acc(1, 1, 8'h00); check("R2 read 0x27", bus_rdata, 8'h42); check("R5 read wrap", cursor_addr, 7'h40);
    acc(1, 1, 8'h00); check("R2 read 0x40", bus_rdata, 8'h45); check("R2 addr", cursor_addr, 7'h41);
    check("R3 read no shift", shift_ofs, 0);

    // R6 blank fill after clear
    acc(0, 0, 8'h06); acc(0, 0, 8'h81); acc(1, 1, 8'h00); acc(1, 1, 8'h00);
    check("R6 blank", bus_rdata, 8'h20);

    // R8 long busy on clear, R6 increment restored
    acc(0, 0, 8'h04); wait_idle(); drive(0, 0, 8'h01);
    busy_len(n); check("R8 clear busy", n, TL); check("R6 clear addr", cursor_addr, 0);
    acc(1, 0, 8'h55); wait_idle(); check("R6 inc forced", cursor_addr, 1);
    acc(0, 0, 8'h18); wait_idle(); check("R4 window left", shift_ofs, 1);
    drive(0, 0, 8'h02); busy_len(n); check("R8 home busy", n, TL);
    check("R6 home addr", cursor_addr, 0); check("R6 home ofs", shift_ofs, 0);
    acc(1, 1, 8'h00); acc(1, 1, 8'h00); check("R6 home keeps memory", bus_rdata, 8'h55);

    // R8 short busy, R10 status while busy, R9 rejected access
    wait_idle(); ac_hold = cursor_addr;
    drive(0, 0, 8'h06);
    drive(0, 1, 8'h00); check("R10 busy status", bus_rdata, {1'b1, ac_hold});
    drive(0, 0, 8'hC5); check("R9 drop pulse", ins_drop, 1);
    drive(1, 0, 8'h77); check("R9 data drop", ins_drop, 1);
    @(negedge clk); check("R9 pulse ends", ins_drop, 0);
    wait_idle(); check("R9 addr kept", cursor_addr, ac_hold);
    drive(0, 0, 8'h06); busy_len(n); check("R8 short busy", n, TS);
    drive(0, 1, 8'h00); check("R10 idle status", bus_rdata, {1'b0, ac_hold});

    // R1 no-op and top-bit decode
    acc(0, 0, 8'h00); check("R1 nop no busy", busy, 0); check("R1 nop addr", cursor_addr, ac_hold);
    acc(0, 0, 8'hFF); wait_idle(); check("R1 top bit", cursor_addr, 7'h7F);

    // R5 one-line wrap and glyph wrap
    acc(0, 0, 8'h30); acc(0, 0, 8'hCF); acc(1, 0, 8'h11); wait_idle();
    check("R5 one-line wrap", cursor_addr, 0);
    acc(0, 0, 8'h38);
    acc(0, 0, 8'h7F); acc(1, 0, 8'h1F); wait_idle(); check("R5 glyph wrap", cursor_addr, 0);
    acc(0, 0, 8'h7F); acc(1, 1, 8'h00); acc(1, 1, 8'h00);
    check("R5 glyph read", bus_rdata, 8'h1F);

    // R11 blink, R12 flags
    acc(0, 0, 8'h0F); check("R12 flags on", {disp_on, cursor_on, blink_on}, 3'b111);
    while (!blink_phase) @(negedge clk);
    n = 0; while (blink_phase) begin n++; @(negedge clk); end
    check("R11 period", n, BC);
    acc(0, 0, 8'h0C); @(negedge clk);
    check("R11 blink off", {blink_on, blink_phase}, 0);
    check("R12 flags set", {disp_on, cursor_on}, 2'b10);

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule